// File: doc/BRIEF.md
# Operand Addressing-Mode Resolver

This block sits between instruction decode and the accumulator and program-counter update logic. When decode has split an instruction into a mode code and an operand field, it pulses `start`. The resolver then produces one of two things. For data modes it returns the operand value. For jump modes it returns a branch target together with a taken/not-taken decision.

The data modes are immediate, direct, indirect and indexed. Immediate needs no memory access. Direct and indexed issue one memory read. Indirect issues two chained reads. Jump targets are either the operand itself (absolute) or an offset from the current instruction (relative). Conditional jumps test the zero flag.

Memory is a synchronous read port. Data appears on `rdData` one cycle after `rdEn` is sampled high. The resolver therefore finishes in zero, one or two extra cycles, depending on the mode.

Top module: `addr_resolver`

## Requirements
- R1: Mode code `mode[2:0]`=000 (immediate) makes `done` high in the same cycle as `start`, with `result` equal to the operand zero-extended. No read is issued.
- R2: Mode code 001 (direct) raises `rdEn` in the start cycle with `rdAddr` equal to the operand. In the next cycle `done` is high and `result` equals `rdData`.
- R3: Mode code 010 (indirect) reads the operand address in the start cycle. In the next cycle it reads the address held in the low `ADDR_W` bits of the returned word. In the cycle after that, `done` is high with `result` equal to the second word.
- R4: Mode code 011 (indexed) behaves like direct, except that the read address is `operand + indexReg` modulo 2^`ADDR_W`.
- R5: Relative jump codes 101 and 111 give a target of `pc - 1 + operand` modulo 2^`ADDR_W`. Here the operand is a signed two's-complement offset and `pc` already points past the current instruction.
- R6: Absolute jump codes 100 and 110 give the operand as the target. Every jump code completes in the start cycle with `isJump` high and no read.
- R7: Codes 100 and 101 are always taken. Codes 110 and 111 are taken when `mode[3]`=0 and `zeroFlag`=1, or when `mode[3]`=1 and `zeroFlag`=0. `jumpTake` is never high for codes 000 to 011.
- R8: A `start` that arrives while a read sequence is still in progress is ignored. The sequence in progress completes on its own schedule and delivers its own result.
- R9: While reset is held, and in the first cycle after it, neither `rdEn` nor `done` is high unless `start` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving the presented operand |
| mode | input | 4 | Bits 2:0 give the mode code; bit 3 is the condition sense |
| operand | input | ADDR_W | Operand field of the instruction |
| pc | input | ADDR_W | Program counter, already incremented |
| indexReg | input | ADDR_W | Index register contents |
| zeroFlag | input | 1 | Zero flag from the status register |
| rdEn | output | 1 | Memory read request |
| rdAddr | output | ADDR_W | Memory read address |
| rdData | input | DATA_W | Memory read data, valid one cycle after `rdEn` |
| result | output | DATA_W | Resolved value or jump target, valid with `done` |
| isJump | output | 1 | `result` is a jump target |
| jumpTake | output | 1 | The jump is taken |
| done | output | 1 | Resolution complete this cycle |

## Verification
The bench drives each mode against the following corner cases.

- **Relative wrap.** The relative target is checked at `pc`=0 and with negative offsets. A design that forgot the minus one would land one instruction late. A design that treated the offset as unsigned would jump forward.
- **Indexed wrap.** Indexed addresses that cross the top of memory are checked. A design that widened the sum would read the wrong word.
- **Indirect second address.** The indirect second read is checked against the returned pointer. A resolver that fetched only once would deliver the pointer instead of the data.
- **Start while busy.** A `start` for immediate mode is held high during an indirect sequence. A design that failed to ignore it would pulse `done` early or abandon the second read.
- **Condition polarity.** Both senses of the condition bit are tested against both zero-flag values. This catches an inverted polarity.

// File: rtl/opr_pkg.sv
package opr_pkg;

  typedef enum logic [2:0] {
    M_IMM    = 3'b000,
    M_DIR    = 3'b001,
    M_IND    = 3'b010,
    M_IDX    = 3'b011,
    M_JABS   = 3'b100,
    M_JREL   = 3'b101,
    M_JABS_C = 3'b110,
    M_JREL_C = 3'b111
  } modeE;

  // Strobes from control to datapath
  typedef struct packed {
    logic issueRead;  // request a memory read this cycle
    logic ptrAddr;    // read address comes from returned data
    logic memResult;  // result comes from returned data
    logic doneStb;    // resolution completes this cycle
  } ctrlS;

endpackage

// File: rtl/opr_ctrl.sv
module opr_ctrl
  import opr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] modeLo,
  output ctrlS       ctrl
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT_PTR, S_WAIT_LAST} stateE;

  stateE state, stateNxt;
  modeE  modeSel;

  assign modeSel = modeE'(modeLo);

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          unique case (modeSel)
            M_DIR, M_IDX: begin
              ctrl.issueRead = 1'b1;
              stateNxt       = S_WAIT_LAST;
            end
            M_IND: begin
              ctrl.issueRead = 1'b1;
              stateNxt       = S_WAIT_PTR;
            end
            default: ctrl.doneStb = 1'b1;
          endcase
        end
      end
      S_WAIT_PTR: begin
        ctrl.issueRead = 1'b1;
        ctrl.ptrAddr   = 1'b1;
        stateNxt       = S_WAIT_LAST;
      end
      S_WAIT_LAST: begin
        ctrl.memResult = 1'b1;
        ctrl.doneStb   = 1'b1;
        stateNxt       = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  // R2
  dir_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && (modeSel == M_DIR || modeSel == M_IDX))
      |=> (ctrl.doneStb && ctrl.memResult && !ctrl.issueRead));

  // R3
  ind_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && modeSel == M_IND)
      |=> (ctrl.issueRead && ctrl.ptrAddr && !ctrl.doneStb));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.ptrAddr |=> (ctrl.memResult && ctrl.doneStb));

  // R8
  return_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.memResult |=> !ctrl.ptrAddr && !ctrl.memResult);

endmodule

// File: rtl/opr_dp.sv
module opr_dp
  import opr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlS              ctrl,
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] operand,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] indexReg,
  input  logic              zeroFlag,
  input  logic [DATA_W-1:0] rdData,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] result,
  output logic              isJump,
  output logic              jumpTake,
  output logic              done
);

  logic [ADDR_W-1:0] effAddr, relTgt, target;
  logic              jumpMode, condOk;

  // sums are ADDR_W wide, so they wrap modulo memory size
  assign effAddr  = (mode[2:0] == M_IDX) ? operand + indexReg : operand;
  assign relTgt   = pc - ADDR_W'(1) + operand;
  assign target   = mode[0] ? relTgt : operand;

  assign jumpMode = mode[2] && !ctrl.memResult;
  assign condOk   = !mode[1] || (zeroFlag ^ mode[3]);

  assign rdEn     = ctrl.issueRead;
  assign rdAddr   = ctrl.ptrAddr ? rdData[ADDR_W-1:0] : effAddr;
  assign done     = ctrl.doneStb;
  assign isJump   = ctrl.doneStb && jumpMode;
  assign jumpTake = ctrl.doneStb && jumpMode && condOk;

  always_comb begin
    if (ctrl.memResult)  result = rdData;
    else if (mode[2])    result = DATA_W'(target);
    else                 result = DATA_W'(operand);
  end

  // R3
  ptr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.ptrAddr |-> $past(ctrl.issueRead));

  // R7
  take_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    jumpTake |-> (isJump && done && !rdEn));

endmodule

// File: rtl/addr_resolver.sv
module addr_resolver
  import opr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] operand,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] indexReg,
  input  logic              zeroFlag,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] result,
  output logic              isJump,
  output logic              jumpTake,
  output logic              done
);

  ctrlS ctrl;

  opr_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .modeLo (mode[2:0]),
    .ctrl   (ctrl)
  );

  opr_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .mode     (mode),
    .operand  (operand),
    .pc       (pc),
    .indexReg (indexReg),
    .zeroFlag (zeroFlag),
    .rdData   (rdData),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .result   (result),
    .isJump   (isJump),
    .jumpTake (jumpTake),
    .done     (done)
  );

  // R1
  imm_noread_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !isJump && !$past(rdEn)) |-> !rdEn);

endmodule

// File: tb/addr_resolver_test.sv
module addr_resolver_test;

  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 0;
  logic          rstN = 0;
  logic          start = 0;
  logic [3:0]    mode = 0;
  logic [AW-1:0] operand = 0, pc = 0, indexReg = 0;
  logic          zeroFlag = 0;
  logic          rdEn;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] rdData = 0;
  logic [DW-1:0] result;
  logic          isJump, jumpTake, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  addr_resolver #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .operand(operand),
    .pc(pc), .indexReg(indexReg), .zeroFlag(zeroFlag), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .result(result), .isJump(isJump),
    .jumpTake(jumpTake), .done(done)
  );

  function automatic logic [DW-1:0] memFn(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = a * 8'd37 + 8'd91;
    return v ^ (a >> 3);
  endfunction

  always @(posedge clk) if (rdEn) rdData <= memFn(rdAddr);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected <= 100000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expTake(input logic [3:0] m, input logic z);
    if (!m[2]) return 1'b0;
    if (!m[1]) return 1'b1;
    return m[3] ? !z : z;
  endfunction

  function automatic logic [AW-1:0] expTarget(input logic [3:0] m, input logic [AW-1:0] op,
                                               input logic [AW-1:0] p);
    return m[0] ? AW'(p - 1 + op) : op;
  endfunction

  // one resolution; holdBusy keeps start high with immediate mode during waits (R8)
  task automatic runOp(input logic [3:0] m, input logic [AW-1:0] op, input logic [AW-1:0] p,
                       input logic [AW-1:0] ix, input logic z, input logic holdBusy);
    logic [AW-1:0] a;
    @(negedge clk);
    mode = m; operand = op; pc = p; indexReg = ix; zeroFlag = z; start = 1;
    #1;
    case (m[2:0])
      3'b000: begin
        chk("R1 done", done, 1); chk("R1 result", result, op); chk("R1 rdEn", rdEn, 0);
        chk("R7 jumpTake", jumpTake, 0);
      end
      3'b001, 3'b011: begin
        a = (m[2:0] == 3'b011) ? AW'(op + ix) : op;
        chk("R2/R4 rdEn", rdEn, 1); chk("R2/R4 rdAddr", rdAddr, a); chk("R2 done", done, 0);
        @(negedge clk);
        if (holdBusy) mode = 4'b0000; else start = 0;
        #1;
        chk("R2/R4 done", done, 1); chk("R2/R4 result", result, memFn(a));
        chk("R2 rdEn", rdEn, 0); chk("R7 jumpTake", jumpTake, 0);
      end
      3'b010: begin
        chk("R3 rdEn1", rdEn, 1); chk("R3 rdAddr1", rdAddr, op); chk("R3 done", done, 0);
        @(negedge clk);
        if (holdBusy) mode = 4'b0000; else start = 0;
        #1;
        chk("R3 rdEn2", rdEn, 1); chk("R3 rdAddr2", rdAddr, memFn(op));
        chk("R8 done while busy", done, 0);
        @(negedge clk); #1;
        chk("R3 done", done, 1); chk("R3 result", result, memFn(memFn(op)));
        chk("R7 jumpTake", jumpTake, 0);
      end
      default: begin
        chk("R6 done", done, 1); chk("R6 isJump", isJump, 1); chk("R6 rdEn", rdEn, 0);
        chk("R5/R6 target", result, expTarget(m, op, p));
        chk("R7 jumpTake", jumpTake, expTake(m, z));
      end
    endcase
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    void'($urandom(1234));
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 rdEn in reset", rdEn, 0); chk("R9 done in reset", done, 0);
    rstN = 1;
    @(negedge clk);
    chk("R9 rdEn after reset", rdEn, 0); chk("R9 done after reset", done, 0);

    // directed corners
    runOp(4'b0000, 8'hA5, 8'h10, 8'h00, 0, 0);   // R1
    runOp(4'b0001, 8'h3C, 8'h10, 8'h00, 0, 0);   // R2
    runOp(4'b0010, 8'h07, 8'h10, 8'h00, 0, 0);   // R3
    runOp(4'b0011, 8'hF0, 8'h10, 8'h20, 0, 0);   // R4 wrap
    runOp(4'b0101, 8'h00, 8'h00, 8'h00, 0, 0);   // R5 pc zero -> FF
    runOp(4'b0101, 8'hFE, 8'h05, 8'h00, 0, 0);   // R5 negative offset -> 02
    runOp(4'b0100, 8'h77, 8'h05, 8'h00, 0, 0);   // R6
    runOp(4'b0110, 8'h11, 8'h05, 8'h00, 1, 0);   // R7 eq taken
    runOp(4'b0110, 8'h11, 8'h05, 8'h00, 0, 0);   // R7 eq not taken
    runOp(4'b1111, 8'h03, 8'h40, 8'h00, 0, 0);   // R7 ne taken
    runOp(4'b1111, 8'h03, 8'h40, 8'h00, 1, 0);   // R7 ne not taken
    runOp(4'b0010, 8'h9A, 8'h00, 8'h00, 0, 1);   // R8 start held during indirect
    runOp(4'b0001, 8'h44, 8'h00, 8'h00, 0, 1);   // R8 start held during direct

    for (int i = 0; i < 400; i++) begin
      runOp(4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
            1'($urandom));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule